// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of external signal lines and turns their transitions into interrupt requests and event pulses for two processor cores. Each line passes through a two-flop synchroniser, and a transition is recognised by comparing the newest synchronised sample with the one before it. Software decides, line by line, whether a rising transition, a falling transition or either one counts as a trigger. Rising triggers and falling triggers are recorded in two separate sticky pending registers, so software can tell which transition fired.

Each core has its own interrupt mask and its own event mask. A core's interrupt output stays high while any pending flag it has enabled is set. A core's event output gives a single-clock pulse for each enabled trigger. The low sixteen lines each pick their source pin from one of several GPIO ports through a per-line selector. The remaining lines come straight from dedicated inputs. A software trigger register lets firmware raise a trigger on any line without a pin transition. Software reaches all registers through a plain memory-mapped bus with a write strobe and a combinational read path.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A pin transition produces a trigger only when that line's rising enable (register 0x00) or falling enable (register 0x04) matches the direction of the transition. With both enable bits cleared, the line never sets a flag.
- R2: A rising trigger sets bit n of the rising-pending register (0x0C). A falling trigger sets bit n of the separate falling-pending register (0x10). A trigger in one direction never touches the other register.
- R3: Pending registers are write-one-to-clear. Each 1 in the write data clears that line's flag. Bits written as 0 keep their value, so writing all zeros changes nothing.
- R4: When a trigger and a clear write for the same flag fall in the same clock cycle, the flag ends up set.
- R5: Interrupt output k is high exactly while some line has a rising or falling pending flag set and also has its bit set in core k's interrupt mask (core k base 0x40 + 0x10*k, interrupt mask at offset 0). The two cores' masks are independent.
- R6: Event output k pulses high for exactly one clock for each cycle in which an enabled trigger hits a line whose bit is set in core k's event mask (offset 4 from the core base). The event output does not depend on the pending flags.
- R7: Line n, for n from 0 to 15, takes its pin from the GPIO port numbered by the 8-bit selector in register 0x20 + 4*(n/4), bits 8*(n mod 4) upward, and uses pin n of that port. A selector value of NPORTS or more feeds a constant 0. Lines 16 and up use the dedicated inputs in order.
- R8: Writing 1 to bit n of the software trigger register (0x08) sets line n's rising-pending flag in the next cycle, whatever the enable bits hold, and counts as a trigger for the event masks. This register always reads 0.
- R9: After reset, every enable, mask and pending register reads 0, every port selector reads 0 (port 0), and all interrupt and event outputs are low.
- R10: A pin transition reaches the pending register and the event output on the third rising clock edge after the pin changes. Two edges go to synchronisation and one to the flag.
- R11: Reads return each register's current contents right-aligned, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| gpio_in | input | NPORTS*16 | GPIO ports, port p on bits 16p to 16p+15 |
| aux_in | input | NLINES-16 | Dedicated inputs for lines 16 and up |
| core_irq | output | NCORES | Level interrupt request for each core |
| core_evt | output | NCORES | One-cycle event pulse for each core |

## Verification
The hardest case to reach from the ports is a collision: a pin edge turns into a trigger in exactly the cycle in which software writes a clear to the same flag. The synchroniser hides the trigger cycle from the bench. The bench therefore counts edges from the pin change: it drives the pin at a falling clock edge and starts the clear write two clock periods later, so the write strobe overlaps the trigger cycle. A check then confirms the flag survives. Port-select routing is tested by toggling the same pin number on a port that is not selected and on the port that is.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int BUS_DW    = 32;
  localparam int BUS_AW    = 8;
  localparam int MUX_LINES = 16;
  localparam int SEL_W     = 8;
  localparam int SEL_PER_REG = BUS_DW / SEL_W;

  localparam logic [BUS_AW-1:0] A_RISE_EN = 8'h00;
  localparam logic [BUS_AW-1:0] A_FALL_EN = 8'h04;
  localparam logic [BUS_AW-1:0] A_SWTRIG  = 8'h08;
  localparam logic [BUS_AW-1:0] A_PEND_R  = 8'h0C;
  localparam logic [BUS_AW-1:0] A_PEND_F  = 8'h10;
  localparam logic [BUS_AW-1:0] A_PSEL0   = 8'h20;
  localparam logic [BUS_AW-1:0] A_CORE0   = 8'h40;
  localparam int               CORE_STRIDE = 16;

  function automatic logic [BUS_AW-1:0] psel_addr(input int idx);
    return A_PSEL0 + BUS_AW'(4 * idx);
  endfunction

  function automatic logic [BUS_AW-1:0] imask_addr(input int core);
    return A_CORE0 + BUS_AW'(CORE_STRIDE * core);
  endfunction

  function automatic logic [BUS_AW-1:0] emask_addr(input int core);
    return A_CORE0 + BUS_AW'(CORE_STRIDE * core + 4);
  endfunction

  function automatic int psel_reg_of(input int line);
    return line / SEL_PER_REG;
  endfunction

  function automatic int psel_lsb_of(input int line);
    return SEL_W * (line % SEL_PER_REG);
  endfunction
endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, samp_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      samp_q <= meta_q;
      prev_q <= samp_q;
    end
  end

  assign rise = samp_q & ~prev_q;
  assign fall = ~samp_q & prev_q;
endmodule

// File: rtl/eic_port_mux.sv
module eic_port_mux
  import eic_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS*MUX_LINES-1:0] gpio_in,
  input  logic [MUX_LINES*SEL_W-1:0]  sel_flat,
  output logic [MUX_LINES-1:0]        line_out
);
  for (genvar l = 0; l < MUX_LINES; l++) begin : g_line
    logic [SEL_W-1:0] sel;
    assign sel = sel_flat[l*SEL_W +: SEL_W];
    always_comb begin
      line_out[l] = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        if (sel == SEL_W'(p)) line_out[l] = gpio_in[p*MUX_LINES + l];
      end
    end
  end
endmodule

// File: rtl/eic_core_out.sv
module eic_core_out #(
  parameter int NL = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] pend_any,
  input  logic [NL-1:0] trig_any,
  input  logic [NL-1:0] imask,
  input  logic [NL-1:0] emask,
  output logic          irq,
  output logic          evt
);
  logic evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= |(trig_any & emask);
  end

  assign irq = |(pend_any & imask);
  assign evt = evt_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NLINES = 20,
  parameter int NPORTS = 4,
  parameter int NCORES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BUS_AW-1:0]           bus_addr,
  input  logic [BUS_DW-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [BUS_DW-1:0]           bus_rdata,
  input  logic [NPORTS*MUX_LINES-1:0] gpio_in,
  input  logic [NLINES-MUX_LINES-1:0] aux_in,
  output logic [NCORES-1:0]           core_irq,
  output logic [NCORES-1:0]           core_evt
);
  localparam int NSEL = MUX_LINES / SEL_PER_REG;

  logic [NLINES-1:0]        rise_en, fall_en, pend_rise, pend_fall;
  logic [NCORES*NLINES-1:0] imask_flat, emask_flat;
  logic [BUS_DW-1:0]        psel_reg [NSEL];
  logic [MUX_LINES*SEL_W-1:0] sel_flat;
  logic [MUX_LINES-1:0]     mux_out;
  logic [NLINES-1:0]        line_src, edge_r, edge_f;
  logic [NLINES-1:0]        sw_pulse, clr_rise, clr_fall;
  logic [NLINES-1:0]        trig_rise, trig_fall;

  for (genvar i = 0; i < NSEL; i++) begin : g_self
    assign sel_flat[i*BUS_DW +: BUS_DW] = psel_reg[i];
  end

  eic_port_mux #(.NPORTS(NPORTS)) u_mux (
    .gpio_in (gpio_in),
    .sel_flat(sel_flat),
    .line_out(mux_out)
  );

  assign line_src = {aux_in, mux_out};

  eic_sync_edge #(.W(NLINES)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (line_src),
    .rise(edge_r),
    .fall(edge_f)
  );

  assign sw_pulse  = (bus_we && bus_addr == A_SWTRIG) ? bus_wdata[NLINES-1:0] : '0;
  assign clr_rise  = (bus_we && bus_addr == A_PEND_R) ? bus_wdata[NLINES-1:0] : '0;
  assign clr_fall  = (bus_we && bus_addr == A_PEND_F) ? bus_wdata[NLINES-1:0] : '0;
  assign trig_rise = (edge_r & rise_en) | sw_pulse;
  assign trig_fall = edge_f & fall_en;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en    <= '0;
      fall_en    <= '0;
      imask_flat <= '0;
      emask_flat <= '0;
      for (int i = 0; i < NSEL; i++) psel_reg[i] <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_RISE_EN) rise_en <= bus_wdata[NLINES-1:0];
      if (bus_addr == A_FALL_EN) fall_en <= bus_wdata[NLINES-1:0];
      for (int i = 0; i < NSEL; i++) begin
        if (bus_addr == psel_addr(i)) psel_reg[i] <= bus_wdata;
      end
      for (int k = 0; k < NCORES; k++) begin
        if (bus_addr == imask_addr(k)) imask_flat[k*NLINES +: NLINES] <= bus_wdata[NLINES-1:0];
        if (bus_addr == emask_addr(k)) emask_flat[k*NLINES +: NLINES] <= bus_wdata[NLINES-1:0];
      end
    end
  end

  // pending flags: set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rise <= '0;
      pend_fall <= '0;
    end else begin
      pend_rise <= (pend_rise & ~clr_rise) | trig_rise;
      pend_fall <= (pend_fall & ~clr_fall) | trig_fall;
    end
  end

  for (genvar k = 0; k < NCORES; k++) begin : g_core
    eic_core_out #(.NL(NLINES)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_any(pend_rise | pend_fall),
      .trig_any(trig_rise | trig_fall),
      .imask   (imask_flat[k*NLINES +: NLINES]),
      .emask   (emask_flat[k*NLINES +: NLINES]),
      .irq     (core_irq[k]),
      .evt     (core_evt[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_RISE_EN) bus_rdata[NLINES-1:0] = rise_en;
    if (bus_addr == A_FALL_EN) bus_rdata[NLINES-1:0] = fall_en;
    if (bus_addr == A_PEND_R)  bus_rdata[NLINES-1:0] = pend_rise;
    if (bus_addr == A_PEND_F)  bus_rdata[NLINES-1:0] = pend_fall;
    for (int i = 0; i < NSEL; i++) begin
      if (bus_addr == psel_addr(i)) bus_rdata = psel_reg[i];
    end
    for (int k = 0; k < NCORES; k++) begin
      if (bus_addr == imask_addr(k)) bus_rdata[NLINES-1:0] = imask_flat[k*NLINES +: NLINES];
      if (bus_addr == emask_addr(k)) bus_rdata[NLINES-1:0] = emask_flat[k*NLINES +: NLINES];
    end
  end
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int NLINES = 20,
  parameter int NCORES = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [BUS_AW-1:0]           bus_addr,
  input logic [BUS_DW-1:0]           bus_wdata,
  input logic                        bus_we,
  input logic [NLINES-1:0]           trig_rise,
  input logic [NLINES-1:0]           trig_fall,
  input logic [NLINES-1:0]           pend_rise,
  input logic [NLINES-1:0]           pend_fall,
  input logic [NLINES-1:0]           fall_en,
  input logic [NCORES*NLINES-1:0]    emask_flat,
  input logic [NCORES-1:0]           core_irq,
  input logic [NCORES-1:0]           core_evt
);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_rise & $past(trig_rise)) == $past(trig_rise)));

  // R2
  rise_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_rise & ~$past(pend_rise) & ~$past(trig_rise)) == '0));

  // R1
  fall_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_fall & ~$past(pend_fall) & ~$past(fall_en)) == '0));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PEND_R) |=>
      ((pend_rise & $past(bus_wdata[NLINES-1:0] & ~trig_rise)) == '0));

  for (genvar k = 0; k < NCORES; k++) begin : g_core
    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_irq[k] && !bus_we) |=> core_irq[k]);

    // R6
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_evt[k] |-> $past(|((trig_rise | trig_fall) & emask_flat[k*NLINES +: NLINES])));
  end
endmodule

bind edge_irq_ctrl eic_checker #(.NLINES(NLINES), .NCORES(NCORES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .trig_rise (trig_rise),
  .trig_fall (trig_fall),
  .pend_rise (pend_rise),
  .pend_fall (pend_fall),
  .fall_en   (fall_en),
  .emask_flat(emask_flat),
  .core_irq  (core_irq),
  .core_evt  (core_evt)
);

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
  localparam int NL = 20;
  localparam int NP = 4;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [NP*16-1:0] gpio_in = '0;
  logic [NL-17:0]   aux_in = '0;
  logic [NC-1:0]    core_irq, core_evt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_irq_ctrl #(.NLINES(NL), .NPORTS(NP), .NCORES(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .gpio_in(gpio_in), .aux_in(aux_in),
    .core_irq(core_irq), .core_evt(core_evt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic settle3();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_check("R9 rise_en", 8'h00, 0);
    rd_check("R9 fall_en", 8'h04, 0);
    rd_check("R9 pend_r", 8'h0C, 0);
    rd_check("R9 pend_f", 8'h10, 0);
    for (int i = 0; i < 4; i++) rd_check("R9 psel", 8'h20 + 8'(4*i), 0);
    rd_check("R9 imask1", 8'h50, 0);
    rd_check("R11 unmapped", 8'h3C, 0);
    check("R9 outputs", {28'd0, core_irq, core_evt}, 0);
  endtask

  task automatic t_rise_only();
    wr(8'h00, 32'h1 << 16);
    rd_check("R11 rise_en readback", 8'h00, 32'h1 << 16);
    @(negedge clk); aux_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd_check("R10 not yet", 8'h0C, 0);
    @(negedge clk);
    rd_check("R10 R2 rise pending", 8'h0C, 32'h1 << 16);
    rd_check("R2 fall untouched", 8'h10, 0);
    @(negedge clk); aux_in[0] = 1'b0;
    settle3();
    rd_check("R1 fall disabled", 8'h10, 0);
  endtask

  task automatic t_both_edges();
    wr(8'h00, (32'h1 << 16) | (32'h1 << 17));
    wr(8'h04, 32'h1 << 17);
    @(negedge clk); aux_in[1] = 1'b1;
    settle3();
    rd_check("R2 both rise", 8'h0C, (32'h1 << 16) | (32'h1 << 17));
    @(negedge clk); aux_in[1] = 1'b0;
    settle3();
    rd_check("R2 both fall", 8'h10, 32'h1 << 17);
  endtask

  task automatic t_clear();
    wr(8'h0C, 32'h1 << 16);
    rd_check("R3 single clear", 8'h0C, 32'h1 << 17);
    wr(8'h0C, 32'h0);
    rd_check("R3 zero write", 8'h0C, 32'h1 << 17);
    wr(8'h10, 32'h1 << 17);
    rd_check("R3 fall clear", 8'h10, 0);
  endtask

  task automatic t_irq();
    wr(8'h40, 32'h1 << 17);
    check("R5 core0 irq", {30'd0, core_irq}, 2'b01);
    wr(8'h50, 32'h1 << 5);
    check("R5 core1 independent", {30'd0, core_irq}, 2'b01);
    wr(8'h0C, 32'h1 << 17);
    check("R5 irq drops", {30'd0, core_irq}, 2'b00);
  endtask

  task automatic t_event();
    wr(8'h54, 32'h1 << 16);
    @(negedge clk); aux_in[0] = 1'b1;
    settle3();
    check("R6 event pulse", {30'd0, core_evt}, 2'b10);
    check("R6 no irq", {30'd0, core_irq}, 2'b00);
    @(negedge clk);
    check("R6 one cycle", {30'd0, core_evt}, 2'b00);
  endtask

  task automatic t_set_wins();
    rd_check("R4 precondition", 8'h0C, 32'h1 << 16);
    @(negedge clk); aux_in[0] = 1'b0;
    settle3();
    @(negedge clk); aux_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    bus_addr = 8'h0C; bus_wdata = 32'h1 << 16; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd_check("R4 set wins", 8'h0C, 32'h1 << 16);
    wr(8'h0C, 32'h1 << 16);
    rd_check("R3 clear after", 8'h0C, 0);
  endtask

  task automatic t_mux();
    wr(8'h00, 32'h1 << 5);
    wr(8'h24, 32'h0000_0200);
    rd_check("R7 psel readback", 8'h24, 32'h0000_0200);
    @(negedge clk); gpio_in[0*16 + 5] = 1'b1;
    settle3();
    rd_check("R7 unselected port", 8'h0C, 0);
    @(negedge clk); gpio_in[2*16 + 5] = 1'b1;
    settle3();
    rd_check("R7 selected port", 8'h0C, 32'h1 << 5);
    check("R5 core1 irq", {30'd0, core_irq}, 2'b10);
    wr(8'h0C, 32'h1 << 5);
    wr(8'h24, 32'h0000_0700);
    wr(8'h24, 32'h0000_0200);
    settle3();
    rd_check("R7 out-of-range port reads 0", 8'h0C, 32'h1 << 5);
    wr(8'h0C, 32'h1 << 5);
  endtask

  task automatic t_sw();
    wr(8'h44, 32'h1 << 3);
    wr(8'h08, 32'h1 << 3);
    check("R8 sw event", {30'd0, core_evt}, 2'b01);
    rd_check("R8 sw pending", 8'h0C, 32'h1 << 3);
    rd_check("R8 sw reads zero", 8'h08, 0);
    rd_check("R8 fall untouched", 8'h10, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise_only();
    t_both_edges();
    t_clear();
    t_irq();
    t_event();
    t_set_wins();
    t_mux();
    t_sw();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule